// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a SPI controller from the module clock. A control word chooses one of two divide laws. The linear law divides the module clock by 2*(N+1), with N taken from an 8-bit field. The power-of-two law divides by 2^N, with N taken from a 4-bit field. The block gives two outputs to a neighbouring shifter. The first is a one-cycle toggle strobe, which fires at twice the serial clock rate. The second is the serial clock level itself.

The divider runs only while the transfer-active input is high. When a transfer starts, the block captures the control word. A word written later has no effect until the next start. While no transfer runs, the half-period counter is held cleared and the serial clock rests at the requested polarity.

The controller has two states. `ST_IDLE` parks the clock and holds the counter cleared. `ST_RUN` counts module cycles and toggles the clock. There are two transitions. START moves `ST_IDLE` to `ST_RUN` when `run` is high; this captures the control word and the polarity. STOP moves `ST_RUN` to `ST_IDLE` when `run` is low. In every other case the state holds.

Top module: `spi_clkdiv`

## Requirements
- R1: While reset is asserted (`rst_n` low), `tick` is 0 and `sclk` is 0.
- R2: In `ST_IDLE`, `tick` stays 0. `sclk` takes the value of `cpol` sampled at each clock edge, so it follows `cpol` one cycle late.
- R3: Field layout of `div_word`. Bits 7:0 hold the linear N. Bits 11:8 hold the power-of-two N. Bit 12 set selects the linear law and bit 12 clear selects the power-of-two law. The field of the law not selected has no effect.
- R4: Under the linear law, `tick` fires once every N+1 module cycles, so `sclk` has a period of 2*(N+1) cycles.
- R5: Under the power-of-two law with N from 1 to 15, `tick` fires once every 2^(N-1) cycles, so `sclk` has a period of 2^N cycles.
- R6: The power-of-two law with N=0 acts as a divide by 2: `tick` fires in every cycle of the transfer.
- R7: Take the edge at which `run` is first sampled high as edge k, and let the half period be H cycles. After edge k, `sclk` equals `cpol` as sampled at edge k. The first `tick` is high in the cycle after edge k+H-1.
- R8: A change to `div_word` during a transfer has no effect on that transfer. The new value applies from the next START.
- R9: A change to `cpol` during a transfer has no effect on that transfer. After STOP, `tick` is 0 and `sclk` equals `cpol` from the next edge on.
- R10: During a transfer, `sclk` inverts at exactly the edges where `tick` is high. At every other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Transfer active |
| cpol | input | 1 | Idle level of the serial clock |
| div_word | input | 13 | Divider control word (layout in R3) |
| tick | output | 1 | Strobe at twice the serial clock rate |
| sclk | output | 1 | Serial clock level |

## Verification
The checker tests these properties at every cycle:
- `tick` is quiet while idle, and the clock parks at the sampled polarity.
- `sclk` toggles exactly on strobe edges and holds between them.
- The captured half period is frozen during a transfer.
- Strobes are never adjacent unless the half period is one cycle.
- A one-cycle half period strobes every cycle.

Some behaviours only the bench scenarios can show:
- The actual strobe spacing for each law and field value.
- The cycle of the first strobe after START.
- That a field of the unselected law is ignored.
- That the word and polarity rewritten mid-transfer apply only at the next START.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/spi_clkdiv_law.sv
// Decodes the control word into a half-period length in module cycles.
module spi_clkdiv_law #(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    parameter int CNT_W = 15
) (
    input  logic [LIN_W+POW_W:0] word,
    output logic [CNT_W-1:0]     half
);
    localparam int SEL_BIT = LIN_W + POW_W;

    logic [LIN_W-1:0] lin_n;
    logic [POW_W-1:0] pow_n;
    logic [CNT_W-1:0] lin_half;
    logic [CNT_W-1:0] pow_half;

    assign lin_n = word[LIN_W-1:0];
    assign pow_n = word[SEL_BIT-1:LIN_W];

    always_comb begin
        lin_half = {{(CNT_W-LIN_W){1'b0}}, lin_n} + CNT_W'(1);
        if (pow_n == '0) begin
            // divide by one is impossible: fall back to divide by two
            pow_half = CNT_W'(1);
        end else begin
            pow_half = CNT_W'(1) << (pow_n - POW_W'(1));
        end
        half = word[SEL_BIT] ? lin_half : pow_half;
    end
endmodule

// File: rtl/spi_clkdiv_fsm.sv
// Two-state transfer controller.
module spi_clkdiv_fsm
    import spi_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic active,
    output logic go,
    output logic load
);
    div_state_e state_q;
    div_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run)  state_d = ST_RUN;   // START
            ST_RUN:  if (!run) state_d = ST_IDLE;  // STOP
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == ST_RUN);
        go     = (state_d == ST_RUN);
        load   = (state_q == ST_IDLE) && (state_d == ST_RUN);
    end
endmodule

// File: rtl/spi_clkdiv_count.sv
// Half-period counter with a shadow of the divide length.
module spi_clkdiv_count #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             go,
    input  logic             load,
    input  logic [CNT_W-1:0] half_in,
    output logic [CNT_W-1:0] half_q,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == half_q - CNT_W'(1));
    assign tick = active && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= CNT_W'(1);
        end else if (load) begin
            half_q <= half_in;
            cnt_q  <= '0;
        end else if (active && go) begin
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/spi_clkdiv_phase.sv
// Serial clock level register.
module spi_clkdiv_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic load,
    input  logic tick,
    input  logic cpol,
    output logic sclk
);
    always_ff @(posedge clk) begin
        if (!rst_n)      sclk <= 1'b0;
        else if (!go)    sclk <= cpol;
        else if (load)   sclk <= cpol;
        else if (tick)   sclk <= ~sclk;
    end
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int LIN_W = 8,
    parameter int POW_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 cpol,
    input  logic [LIN_W+POW_W:0] div_word,
    output logic                 tick,
    output logic                 sclk
);
    localparam int PW_MAX = (1 << POW_W) - 1;
    localparam int CNT_W  = (LIN_W + 1 > PW_MAX) ? LIN_W + 1 : PW_MAX;

    logic             st_active;
    logic             st_go;
    logic             st_load;
    logic [CNT_W-1:0] half_next;
    logic [CNT_W-1:0] half_shadow;

    spi_clkdiv_law #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) u_law (
        .word (div_word),
        .half (half_next)
    );

    spi_clkdiv_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .active (st_active),
        .go     (st_go),
        .load   (st_load)
    );

    spi_clkdiv_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st_active),
        .go      (st_go),
        .load    (st_load),
        .half_in (half_next),
        .half_q  (half_shadow),
        .tick    (tick)
    );

    spi_clkdiv_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (st_go),
        .load  (st_load),
        .tick  (tick),
        .cpol  (cpol),
        .sclk  (sclk)
    );
endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cpol,
    input logic             tick,
    input logic             sclk,
    input logic             active,
    input logic [CNT_W-1:0] half_q
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)));

    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run) |=> (sclk != $past(sclk)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run && !tick) |=> $stable(sclk));

    p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run) |=> $stable(half_q));

    p_n0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && half_q == CNT_W'(1)) |-> tick);

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && half_q != CNT_W'(1)) |=> !tick);
endmodule

bind spi_clkdiv spi_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cpol   (cpol),
    .tick   (tick),
    .sclk   (sclk),
    .active (st_active),
    .half_q (half_shadow)
);

// File: tb/spi_clkdiv_tb_top.sv
module spi_clkdiv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] div_word = '0;
    logic        tick;
    logic        sclk;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_clkdiv dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cpol     (cpol),
        .div_word (div_word),
        .tick     (tick),
        .sclk     (sclk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // half period from the R3 layout, R4/R5/R6 laws
    function automatic int exp_half(input logic [12:0] w);
        if (w[12]) return int'(w[7:0]) + 1;
        if (w[11:8] == 4'd0) return 1;
        return 1 << (int'(w[11:8]) - 1);
    endfunction

    task automatic xfer(input logic [12:0] w, input bit pol, input int len,
                        input bit disturb, input string tag);
        int h;
        h = exp_half(w);
        @(negedge clk);
        div_word = w;
        cpol = pol;
        run = 1'b1;
        @(posedge clk);
        for (int j = 0; j < len; j++) begin
            bit e_tick;
            bit e_sclk;
            string t;
            @(negedge clk);
            e_tick = ((j % h) == h - 1);
            e_sclk = pol ^ bit'((j / h) % 2);
            t = (j == h - 1) ? "R7" : tag;
            if (disturb && j > len / 2) t = "R8";
            chk(tick == e_tick, t, tick, e_tick);
            chk(sclk == e_sclk, (disturb && j > len / 2) ? "R9" : "R10", sclk, e_sclk);
            if (disturb && j == len / 2) begin
                div_word = 13'($urandom);
                cpol = ~pol;
            end
        end
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(tick == 1'b0, "R9", tick, 0);
        chk(sclk == cpol, "R9", sclk, cpol);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd90210);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tick == 1'b0, "R1", tick, 0);
        chk(sclk == 1'b0, "R1", sclk, 0);
        rst_n = 1'b1;
        // R2: idle tracking with one-cycle lag
        cpol = 1'b1;
        div_word = 13'h1001;
        chk(sclk == 1'b0, "R2", sclk, 0);
        @(posedge clk);
        @(negedge clk);
        chk(sclk == 1'b1, "R2", sclk, 1);
        chk(tick == 1'b0, "R2", tick, 0);
        repeat (3) begin
            @(negedge clk);
            chk(tick == 1'b0, "R2", tick, 0);
        end
        // directed corners
        xfer({1'b1, 4'd0, 8'd0},   1'b0, 6,     1'b0, "R4");
        xfer({1'b1, 4'd0, 8'd255}, 1'b1, 520,   1'b0, "R4");
        xfer({1'b0, 4'd0, 8'd77},  1'b0, 5,     1'b0, "R6");
        xfer({1'b0, 4'd1, 8'd0},   1'b1, 5,     1'b0, "R5");
        xfer({1'b0, 4'd15, 8'd3},  1'b0, 16386, 1'b0, "R5");
        xfer({1'b1, 4'd9, 8'd3},   1'b0, 12,    1'b0, "R3");
        xfer({1'b0, 4'd3, 8'd200}, 1'b1, 12,    1'b0, "R3");
        xfer({1'b1, 4'd0, 8'd2},   1'b1, 20,    1'b1, "R8");
        // constrained random
        for (int i = 0; i < 24; i++) begin
            logic [12:0] w;
            int h;
            string tg;
            w[12]   = 1'($urandom % 2);
            w[11:8] = 4'($urandom % 7);
            w[7:0]  = 8'($urandom % 64);
            h = exp_half(w);
            tg = w[12] ? "R4" : ((w[11:8] == 4'd0) ? "R6" : "R5");
            xfer(w, 1'($urandom % 2), 3 * h + int'($urandom % 5) + 1,
                 1'($urandom % 2), tg);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule